// File: doc/BRIEF.md
# Bypass Prefetch Tag Allocator

This block hands out 7-bit prefetch tags to queues that run in simple bypass mode. Tags are entries of a small associative table that holds the ids of the active queues. Software asks for a tag in two steps. It writes a queue id to a request register, then reads a result register that returns the tag granted to that queue. The result register can also report that the request was refused, or that every tag is taken. Each tag belongs to a host-side queue id, not to a descriptor ring. It stays reserved until that queue is marked invalid. At that point the entry is freed and a new request is needed.

At run time, every bypass descriptor carries its reserved tag and the real queue id of its packet. The block turns the tag back into the queue id that reserved it, and flags a tag that nobody holds. Data packets carry two queue ids. The control queue id is the one used for the request. The packet queue id is the real one. Several queues can share one tag, and descriptors and data packets for that tag must arrive in the same queue order. A per-tag ordering checker remembers the packet queue ids of accepted descriptors in arrival order. Each data packet is compared against the oldest of them, and every outcome is reported as a one-cycle pulse.

Top module: `byp_tag_alloc`

## Requirements
- R1: The register bus has a read latency of one cycle. After a read strobe, `reg_rdata` in the next cycle holds the addressed register. Reading 0x1408 returns the last requested queue id in the low bits. Reading 0x140C returns the result word: bit 31 is the valid flag, bits 9:8 are the outcome code and bits 6:0 are the tag. In a cycle that follows no read, and for any other address, `reg_rdata` is zero.
- R2: A write to 0x1408 for an eligible queue with no tag grants the lowest-numbered free tag. The result word then reads as valid, with outcome code 0 and that tag.
- R3: A repeat request for a queue id that already holds a tag returns that same tag, with valid set and code 0. It takes no new entry.
- R4: A request for a queue whose `q_valid` bit or `q_sbyp` bit is low is refused. The result has valid clear, code 1 and tag 0, and no entry is taken.
- R5: When all NT entries are in use, a request for a new queue id returns valid clear, code 2 and tag 0.
- R6: When the `q_valid` bit of a queue that holds a tag is low at a clock edge, that tag is freed at that edge. Later lookups of the tag fail, and the tag can be granted again.
- R7: A descriptor whose tag is held pulses `lk_vld` one cycle later, with `lk_qid` equal to the queue id that reserved the tag.
- R8: A descriptor whose tag is free, or is NT or above, pulses `lk_err` one cycle later. In that cycle `lk_vld` is 0 and `lk_qid` is 0.
- R9: A data packet whose control queue id holds no tag pulses `ctl_err` one cycle later and consumes nothing.
- R10: A data packet for a held tag is compared with the oldest pending descriptor queue id of that tag, and that entry is consumed. One cycle later the block pulses `dat_ok` on a match. It pulses `ord_err` on a mismatch, or when nothing is pending. A descriptor and a data packet in the same cycle see only the entries pending before that cycle.
- R11: Each tag keeps at most DEPTH pending descriptor ids. A descriptor that arrives when its tag is full still gives `lk_vld`, but its id is dropped and `ord_err` pulses.
- R12: Freeing a tag discards every pending descriptor id of that tag, so a packet that follows a fresh grant of the tag finds nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 32 | Write data; the low QW bits carry the queue id |
| reg_rdata | output | 32 | Read data, one cycle after the read strobe |
| q_valid | input | 2^QW | Per-queue valid flags |
| q_sbyp | input | 2^QW | Per-queue simple bypass flags |
| desc_vld | input | 1 | Bypass descriptor present |
| desc_tag | input | 7 | Tag carried by the descriptor |
| desc_qid | input | QW | Real queue id of the descriptor |
| dat_vld | input | 1 | Data packet present |
| dat_ctrl_qid | input | QW | Queue id that was used for the tag request |
| dat_pkt_qid | input | QW | Real queue id of the packet |
| lk_vld | output | 1 | Tag resolved |
| lk_qid | output | QW | Queue id that holds the resolved tag |
| lk_err | output | 1 | Descriptor tag not held |
| ctl_err | output | 1 | Data control queue id holds no tag |
| dat_ok | output | 1 | Data packet matched the descriptor order |
| ord_err | output | 1 | Order mismatch, empty pop or pending overflow |

## Verification
Some properties are checked on every cycle by assertions. No queue id is held by two table entries. A freed entry is invalid one cycle later, and its pending count is zero one cycle after a flush. The pending count never exceeds DEPTH. The read data is zero after any cycle without a read. The lookup pulses and data pulses never contradict each other. Other behaviour only shows up over a sequence of stimulus, so the bench scenarios have to demonstrate it: lowest-free-tag choice, the repeat grant, refusal and full codes, reuse of a freed tag, the flush of pending ids, and the comparison of descriptor order against data order when pushes and pops land in the same cycle.

// File: rtl/byp_tag_pkg.sv
package byp_tag_pkg;

    localparam int TAG_W = 7;

    localparam logic [15:0] ADDR_QID = 16'h1408;
    localparam logic [15:0] ADDR_TAG = 16'h140C;

    typedef enum logic [1:0] {
        RES_GRANT  = 2'd0,
        RES_REJECT = 2'd1,
        RES_FULL   = 2'd2
    } res_code_e;

    typedef struct packed {
        logic              vld;
        res_code_e         code;
        logic [TAG_W-1:0]  tag;
    } alloc_res_t;

    // Result word: valid in bit 31, code in bits 9:8, tag in bits 6:0
    function automatic logic [31:0] pack_res(alloc_res_t r);
        return {r.vld, 21'd0, r.code, 1'b0, r.tag};
    endfunction

endpackage

// File: rtl/byp_tag_cam.sv
module byp_tag_cam
    import byp_tag_pkg::*;
#(
    parameter int QW = 6,
    parameter int NT = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [(1<<QW)-1:0]      q_valid,
    input  logic [(1<<QW)-1:0]      q_sbyp,
    input  logic                    req_vld,
    input  logic [QW-1:0]           req_qid,
    output alloc_res_t              req_res,
    input  logic [TAG_W-1:0]        lk_tag,
    output logic                    lk_hit,
    output logic [QW-1:0]           lk_qid,
    input  logic [QW-1:0]           dq_qid,
    output logic                    dq_hit,
    output logic [$clog2(NT)-1:0]   dq_idx,
    output logic [NT-1:0]           rel_mask
);

    localparam int TIW = $clog2(NT);

    typedef struct packed {
        logic [NT-1:0]          vld;
        logic [NT-1:0][QW-1:0]  qid;
    } cam_t;

    cam_t st_d, st_q;

    logic            req_hit;
    logic [TIW-1:0]  req_idx;
    logic            any_free;
    logic [TIW-1:0]  free_idx;
    logic            q_ok;
    logic            lk_in_range;
    logic [TIW-1:0]  lk_idx;

    always_comb begin
        st_d     = st_q;
        req_hit  = 1'b0;
        req_idx  = '0;
        any_free = 1'b0;
        free_idx = '0;
        dq_hit   = 1'b0;
        dq_idx   = '0;

        // lowest free entry wins: scan from the top down
        for (int i = NT - 1; i >= 0; i--) begin
            if (!st_q.vld[i]) begin
                any_free = 1'b1;
                free_idx = TIW'(i);
            end
        end

        // associative match on request and data-side queue ids
        for (int i = 0; i < NT; i++) begin
            rel_mask[i] = st_q.vld[i] && !q_valid[st_q.qid[i]];
            if (st_q.vld[i] && (st_q.qid[i] == req_qid)) begin
                req_hit = 1'b1;
                req_idx = TIW'(i);
            end
            if (st_q.vld[i] && (st_q.qid[i] == dq_qid)) begin
                dq_hit = 1'b1;
                dq_idx = TIW'(i);
            end
        end

        // direct-indexed lookup of the descriptor tag
        lk_in_range = ({1'b0, lk_tag} < (TAG_W + 1)'(NT));
        lk_idx      = lk_tag[TIW-1:0];
        lk_hit      = lk_in_range && st_q.vld[lk_idx];
        lk_qid      = st_q.qid[lk_idx];

        // allocation decision
        q_ok         = q_valid[req_qid] && q_sbyp[req_qid];
        req_res.vld  = 1'b0;
        req_res.code = RES_GRANT;
        req_res.tag  = '0;
        if (!q_ok) begin
            req_res.code = RES_REJECT;
        end else if (req_hit) begin
            req_res.vld = 1'b1;
            req_res.tag = TAG_W'(req_idx);
        end else if (any_free) begin
            req_res.vld = 1'b1;
            req_res.tag = TAG_W'(free_idx);
            if (req_vld) begin
                st_d.vld[free_idx] = 1'b1;
                st_d.qid[free_idx] = req_qid;
            end
        end else begin
            req_res.code = RES_FULL;
        end

        // release entries whose queue has been invalidated
        for (int i = 0; i < NT; i++) begin
            if (rel_mask[i]) begin
                st_d.vld[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    function automatic logic dup_qid(cam_t s);
        for (int i = 0; i < NT; i++) begin
            for (int j = i + 1; j < NT; j++) begin
                if (s.vld[i] && s.vld[j] && (s.qid[i] == s.qid[j])) begin
                    return 1'b1;
                end
            end
        end
        return 1'b0;
    endfunction

    // R3: a queue id never occupies two entries
    a_r3_unique_qid: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_qid(st_q));

    for (genvar g = 0; g < NT; g++) begin : g_rel_chk
        // R6: an invalidated queue's entry is gone on the next cycle
        a_r6_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
            rel_mask[g] |=> !st_q.vld[g]);
    end

endmodule

// File: rtl/byp_tag_regs.sv
module byp_tag_regs
    import byp_tag_pkg::*;
#(
    parameter int QW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [15:0]     reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            req_vld,
    output logic [QW-1:0]   req_qid,
    input  alloc_res_t      req_res
);

    typedef struct packed {
        logic [QW-1:0]  qreg;
        alloc_res_t     res;
        logic [31:0]    rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata[31:QW];

    always_comb begin
        r_d     = r_q;
        req_vld = reg_wr && (reg_addr == ADDR_QID);
        req_qid = reg_wdata[QW-1:0];

        if (req_vld) begin
            r_d.qreg = req_qid;
            r_d.res  = req_res;
        end

        r_d.rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                ADDR_TAG: r_d.rdata = pack_res(r_q.res);
                ADDR_QID: r_d.rdata = 32'(r_q.qreg);
                default:  r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign reg_rdata = r_q.rdata;

    // R1: read data is quiet in any cycle not preceded by a read
    a_r1_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> (reg_rdata == '0));

endmodule

// File: rtl/byp_tag_order.sv
module byp_tag_order #(
    parameter int QW    = 6,
    parameter int NT    = 8,
    parameter int DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push_vld,
    input  logic [$clog2(NT)-1:0]   push_idx,
    input  logic [QW-1:0]           push_qid,
    input  logic                    pop_vld,
    input  logic [$clog2(NT)-1:0]   pop_idx,
    input  logic [QW-1:0]           pop_qid,
    input  logic [NT-1:0]           flush_mask,
    output logic                    ord_ok,
    output logic                    ord_err
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [NT-1:0][DEPTH-1:0][QW-1:0]  mem;
        logic [NT-1:0][PW-1:0]             rp;
        logic [NT-1:0][PW-1:0]             wp;
        logic [NT-1:0][CW-1:0]             cnt;
    } ord_t;

    ord_t s_d, s_q;

    logic           do_push;
    logic           do_pop;
    logic [NT-1:0]  inc;
    logic [NT-1:0]  dec;

    function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        s_d     = s_q;
        ord_ok  = 1'b0;
        ord_err = 1'b0;

        do_pop  = pop_vld  && (s_q.cnt[pop_idx]  != '0);
        do_push = push_vld && (s_q.cnt[push_idx] != CW'(DEPTH));

        if (pop_vld) begin
            if (!do_pop) begin
                ord_err = 1'b1;
            end else if (s_q.mem[pop_idx][s_q.rp[pop_idx]] == pop_qid) begin
                ord_ok = 1'b1;
            end else begin
                ord_err = 1'b1;
            end
        end
        if (push_vld && !do_push) begin
            ord_err = 1'b1;
        end

        for (int t = 0; t < NT; t++) begin
            inc[t] = do_push && (push_idx == t[$clog2(NT)-1:0]);
            dec[t] = do_pop  && (pop_idx  == t[$clog2(NT)-1:0]);
            if (inc[t]) begin
                s_d.mem[t][s_q.wp[t]] = push_qid;
                s_d.wp[t]             = ptr_next(s_q.wp[t]);
            end
            if (dec[t]) begin
                s_d.rp[t] = ptr_next(s_q.rp[t]);
            end
            s_d.cnt[t] = s_q.cnt[t] + CW'(inc[t]) - CW'(dec[t]);
            if (flush_mask[t]) begin
                s_d.cnt[t] = '0;
                s_d.rp[t]  = '0;
                s_d.wp[t]  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar g = 0; g < NT; g++) begin : g_ord_chk
        // R11: pending ids per tag never exceed the depth
        a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.cnt[g] <= CW'(DEPTH));
        // R12: a freed tag has nothing pending afterwards
        a_r12_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
            flush_mask[g] |=> (s_q.cnt[g] == '0));
    end

endmodule

// File: rtl/byp_tag_alloc.sv
module byp_tag_alloc
    import byp_tag_pkg::*;
#(
    parameter int QW    = 6,
    parameter int NT    = 8,
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [15:0]         reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [(1<<QW)-1:0]  q_valid,
    input  logic [(1<<QW)-1:0]  q_sbyp,
    input  logic                desc_vld,
    input  logic [6:0]          desc_tag,
    input  logic [QW-1:0]       desc_qid,
    input  logic                dat_vld,
    input  logic [QW-1:0]       dat_ctrl_qid,
    input  logic [QW-1:0]       dat_pkt_qid,
    output logic                lk_vld,
    output logic [QW-1:0]       lk_qid,
    output logic                lk_err,
    output logic                ctl_err,
    output logic                dat_ok,
    output logic                ord_err
);

    localparam int TIW = $clog2(NT);

    typedef struct packed {
        logic           lk_vld;
        logic [QW-1:0]  lk_qid;
        logic           lk_err;
        logic           ctl_err;
        logic           dat_ok;
        logic           ord_err;
    } out_t;

    out_t o_d, o_q;

    logic            req_vld;
    logic [QW-1:0]   req_qid;
    alloc_res_t      req_res;
    logic            cam_lk_hit;
    logic [QW-1:0]   cam_lk_qid;
    logic            dq_hit;
    logic [TIW-1:0]  dq_idx;
    logic [NT-1:0]   rel_mask;
    logic            push_vld;
    logic            pop_vld;
    logic            ord_ok_c;
    logic            ord_err_c;

    byp_tag_regs #(.QW(QW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .req_vld   (req_vld),
        .req_qid   (req_qid),
        .req_res   (req_res)
    );

    byp_tag_cam #(.QW(QW), .NT(NT)) u_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .q_valid  (q_valid),
        .q_sbyp   (q_sbyp),
        .req_vld  (req_vld),
        .req_qid  (req_qid),
        .req_res  (req_res),
        .lk_tag   (desc_tag),
        .lk_hit   (cam_lk_hit),
        .lk_qid   (cam_lk_qid),
        .dq_qid   (dat_ctrl_qid),
        .dq_hit   (dq_hit),
        .dq_idx   (dq_idx),
        .rel_mask (rel_mask)
    );

    assign push_vld = desc_vld && cam_lk_hit;
    assign pop_vld  = dat_vld && dq_hit;

    byp_tag_order #(.QW(QW), .NT(NT), .DEPTH(DEPTH)) u_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_vld   (push_vld),
        .push_idx   (desc_tag[TIW-1:0]),
        .push_qid   (desc_qid),
        .pop_vld    (pop_vld),
        .pop_idx    (dq_idx),
        .pop_qid    (dat_pkt_qid),
        .flush_mask (rel_mask),
        .ord_ok     (ord_ok_c),
        .ord_err    (ord_err_c)
    );

    always_comb begin
        o_d         = '0;
        o_d.lk_vld  = push_vld;
        o_d.lk_qid  = push_vld ? cam_lk_qid : '0;
        o_d.lk_err  = desc_vld && !cam_lk_hit;
        o_d.ctl_err = dat_vld && !dq_hit;
        o_d.dat_ok  = ord_ok_c;
        o_d.ord_err = ord_err_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign lk_vld  = o_q.lk_vld;
    assign lk_qid  = o_q.lk_qid;
    assign lk_err  = o_q.lk_err;
    assign ctl_err = o_q.ctl_err;
    assign dat_ok  = o_q.dat_ok;
    assign ord_err = o_q.ord_err;

    // R8: a descriptor either resolves or errors, never both
    a_r8_lookup_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_vld && lk_err));

    // R8: failed lookups carry no queue id
    a_r8_qid_zero_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_vld |-> (lk_qid == '0));

    // R9: a packet without a tag consumes nothing, so it cannot match
    a_r9_ctl_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_err |-> !dat_ok);

endmodule

// File: tb/sim_byp_tag_alloc.sv
module sim_byp_tag_alloc;

    localparam int QW = 6;
    localparam int NT = 8;
    localparam int DEPTH = 4;
    localparam int NQ = 1 << QW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic            reg_rd = 1'b0;
    logic [15:0]     reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NQ-1:0]   q_valid;
    logic [NQ-1:0]   q_sbyp;
    logic            desc_vld = 1'b0;
    logic [6:0]      desc_tag = '0;
    logic [QW-1:0]   desc_qid = '0;
    logic            dat_vld = 1'b0;
    logic [QW-1:0]   dat_ctrl_qid = '0;
    logic [QW-1:0]   dat_pkt_qid = '0;
    logic            lk_vld;
    logic [QW-1:0]   lk_qid;
    logic            lk_err;
    logic            ctl_err;
    logic            dat_ok;
    logic            ord_err;

    always #10 clk = ~clk;

    byp_tag_alloc #(.QW(QW), .NT(NT), .DEPTH(DEPTH)) u0 (.*);

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // ---------------- behavioural reference model ----------------
    bit          m_vld [NT];
    int          m_qid [NT];
    int          m_fifo [NT][$];
    int          m_qreg;
    logic [31:0] m_res;
    logic [31:0] e_rdata;
    logic        e_lk_vld, e_lk_err, e_ctl_err, e_dat_ok, e_ord_err;
    logic [QW-1:0] e_lk_qid;
    int pt, pp, psz, q, hd;
    bit found;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NT; t++) begin
                m_vld[t] = 0;
                m_qid[t] = 0;
                m_fifo[t].delete();
            end
            m_qreg = 0; m_res = '0; e_rdata = '0;
            e_lk_vld = 0; e_lk_qid = '0; e_lk_err = 0;
            e_ctl_err = 0; e_dat_ok = 0; e_ord_err = 0;
        end else begin
            e_rdata = '0;
            if (reg_rd) begin
                if (reg_addr == 16'h140C) e_rdata = m_res;
                else if (reg_addr == 16'h1408) e_rdata = 32'(m_qreg);
            end
            e_lk_vld = 0; e_lk_qid = '0; e_lk_err = 0; pt = -1;
            if (desc_vld) begin
                if (int'(desc_tag) < NT && m_vld[desc_tag]) begin
                    e_lk_vld = 1; e_lk_qid = QW'(m_qid[desc_tag]); pt = int'(desc_tag);
                end else begin
                    e_lk_err = 1;
                end
            end
            e_ctl_err = 0; e_dat_ok = 0; e_ord_err = 0; pp = -1;
            if (dat_vld) begin
                for (int t = 0; t < NT; t++)
                    if (m_vld[t] && m_qid[t] == int'(dat_ctrl_qid)) pp = t;
                if (pp < 0) e_ctl_err = 1;
            end
            psz = (pt >= 0) ? m_fifo[pt].size() : 0;
            if (pp >= 0) begin
                if (m_fifo[pp].size() == 0) e_ord_err = 1;
                else begin
                    hd = m_fifo[pp].pop_front();
                    if (hd == int'(dat_pkt_qid)) e_dat_ok = 1; else e_ord_err = 1;
                end
            end
            if (pt >= 0) begin
                if (psz == DEPTH) e_ord_err = 1;
                else m_fifo[pt].push_back(int'(desc_qid));
            end
            if (reg_wr && reg_addr == 16'h1408) begin
                q = int'(reg_wdata[QW-1:0]);
                m_qreg = q;
                if (!q_valid[q] || !q_sbyp[q]) m_res = 32'h0000_0100;
                else begin
                    found = 0;
                    for (int t = 0; t < NT; t++)
                        if (!found && m_vld[t] && m_qid[t] == q) begin
                            found = 1; m_res = 32'h8000_0000 | 32'(t);
                        end
                    for (int t = 0; t < NT; t++)
                        if (!found && !m_vld[t]) begin
                            found = 1; m_vld[t] = 1; m_qid[t] = q;
                            m_res = 32'h8000_0000 | 32'(t);
                        end
                    if (!found) m_res = 32'h0000_0200;
                end
            end
            for (int t = 0; t < NT; t++)
                if (m_vld[t] && !q_valid[m_qid[t]]) begin
                    m_vld[t] = 0;
                    m_fifo[t].delete();
                end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        chk(reg_rdata, e_rdata, "R1 rdata");
        chk({lk_vld, lk_qid}, {e_lk_vld, e_lk_qid}, "R7 lookup");
        chk(32'(lk_err), 32'(e_lk_err), "R8 lk_err");
        chk(32'(ctl_err), 32'(e_ctl_err), "R9 ctl_err");
        chk({dat_ok, ord_err}, {e_dat_ok, e_ord_err}, "R10 order");
    endtask

    task automatic do_req(input int qid, input logic [31:0] exp, input string req);
        reg_wr = 1; reg_addr = 16'h1408; reg_wdata = 32'(qid);
        step();
        reg_wr = 0; reg_rd = 1; reg_addr = 16'h140C;
        step();
        reg_rd = 0;
        chk(reg_rdata, exp, req);
    endtask

    task automatic send_desc(input int tag, input int qid);
        desc_vld = 1; desc_tag = 7'(tag); desc_qid = QW'(qid);
        step();
        desc_vld = 0;
    endtask

    task automatic send_dat(input int cq, input int pq);
        dat_vld = 1; dat_ctrl_qid = QW'(cq); dat_pkt_qid = QW'(pq);
        step();
        dat_vld = 0;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        report();
    end

    initial begin
        q_valid = '1; q_valid[63] = 1'b0;
        q_sbyp  = '1; q_sbyp[62]  = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // reset state of all outputs
        chk(reg_rdata, 32'h0, "R1 reset rdata");
        chk({lk_vld, lk_err, ctl_err, dat_ok, ord_err}, '0, "R8 reset pulses");
        rst_n = 1;

        // R2 lowest free tag, R3 repeat request
        do_req(5,  32'h8000_0000, "R2 first grant");
        do_req(9,  32'h8000_0001, "R2 second grant");
        do_req(5,  32'h8000_0000, "R3 repeat grant");
        reg_rd = 1; reg_addr = 16'h1408; step(); reg_rd = 0;
        chk(reg_rdata, 32'd5, "R1 qid readback");
        reg_rd = 1; reg_addr = 16'h1400; step(); reg_rd = 0;
        chk(reg_rdata, 32'd0, "R1 other address");

        // R4 refusals leave the table untouched
        do_req(63, 32'h0000_0100, "R4 invalid queue");
        do_req(62, 32'h0000_0100, "R4 non-bypass queue");
        do_req(11, 32'h8000_0002, "R4 no entry taken");

        // R7 / R8 lookups
        send_desc(0, 20);
        chk({lk_vld, lk_qid}, {1'b1, 6'd5}, "R7 resolve tag 0");
        send_desc(3, 20);
        chk({lk_err, lk_vld, lk_qid}, {1'b1, 1'b0, 6'd0}, "R8 free tag");
        send_desc(100, 20);
        chk(32'(lk_err), 32'd1, "R8 out of range tag");

        // R10 ordering across queues sharing tag 0
        send_desc(0, 21);
        send_dat(5, 20);
        chk({dat_ok, ord_err}, 2'b10, "R10 in order");
        send_dat(5, 22);
        chk({dat_ok, ord_err}, 2'b01, "R10 out of order");
        send_dat(5, 20);
        chk({dat_ok, ord_err}, 2'b01, "R10 nothing pending");
        send_dat(40, 1);
        chk({ctl_err, dat_ok}, 2'b10, "R9 untagged control qid");

        // R11 pending overflow on tag 1
        for (int k = 0; k < DEPTH; k++) send_desc(1, 9);
        send_desc(1, 9);
        chk({lk_vld, ord_err}, 2'b11, "R11 overflow dropped");

        // R5 fill the table
        for (int k = 0; k < 5; k++) do_req(12 + k, 32'h8000_0000 | 32'(3 + k), "R2 fill");
        do_req(17, 32'h0000_0200, "R5 table full");

        // R6 release on invalidation, R12 flush of pending ids
        q_valid[9] = 1'b0; step(); q_valid[9] = 1'b1;
        send_desc(1, 3);
        chk(32'(lk_err), 32'd1, "R6 freed tag lookup");
        do_req(17, 32'h8000_0001, "R6 freed tag reused");
        send_dat(17, 9);
        chk({dat_ok, ord_err}, 2'b01, "R12 pending flushed");

        // R10 same-cycle push and pop on tag 2
        desc_vld = 1; desc_tag = 7'd2; desc_qid = 6'd30;
        dat_vld = 1; dat_ctrl_qid = 6'd11; dat_pkt_qid = 6'd30;
        step();
        desc_vld = 0; dat_vld = 0;
        chk({dat_ok, ord_err}, 2'b01, "R10 pop sees prior contents");
        send_dat(11, 30);
        chk({dat_ok, ord_err}, 2'b10, "R10 pushed entry consumed");

        // mixed stimulus, model compared every cycle
        for (int k = 0; k < 600; k++) begin
            desc_vld = ($urandom % 3) == 0;
            desc_tag = 7'($urandom % 10);
            desc_qid = QW'($urandom % 24);
            dat_vld = ($urandom % 3) == 0;
            dat_ctrl_qid = QW'($urandom % 20);
            dat_pkt_qid = QW'($urandom % 24);
            reg_wr = ($urandom % 8) == 0;
            reg_rd = ($urandom % 4) == 0;
            case ($urandom % 3)
                0: reg_addr = 16'h1408;
                1: reg_addr = 16'h140C;
                default: reg_addr = 16'h1404;
            endcase
            if (reg_wr) reg_addr = 16'h1408;
            reg_wdata = $urandom % 24;
            q_valid = '1; q_valid[63] = 1'b0;
            if (($urandom % 10) == 0) q_valid[$urandom % 24] = 1'b0;
            step();
        end
        desc_vld = 0; dat_vld = 0; reg_wr = 0; reg_rd = 0;
        step();
        report();
    end

endmodule